// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Manager

This block keeps an asynchronous DRAM array refreshed. An interval timer counts system clock cycles and adds one owed refresh to a small backlog counter each time it expires. While anything is owed, the block asks the neighbouring access sequencer for the RAS#/CAS# strobes through a request/grant handshake. Once granted, it runs a CAS-before-RAS (CBR) cycle: a precharge wait with both strobes high, then CAS# low, then RAS# low, and finally both strobes high again. No row address is driven, because the DRAM takes the row from its own counter. A backlog that built up while the sequencer held the bus in a long page burst is then worked off one cycle after another.

On a level command the block uses a CBR cycle to enter self refresh and keeps both strobes low for at least a minimum hold time. Once the command is dropped it raises both strobes and keeps them high for a guard time before access is allowed again. If the system uses burst refresh rather than distributed refresh, a catch-up burst that covers every row runs before control returns to the sequencer. A mode input selects the long interval used by parts with an extended refresh period.

The states are IDLE (standby, access allowed), PRE (precharge wait), CAS (CAS# low lead), RAS (both low, refresh in progress), SELF (self refresh hold) and RPS (exit guard). The transitions are:
- IDLE→PRE on a grant.
- PRE→CAS, CAS→RAS and RPS→IDLE, each when its count ends.
- RAS→SELF if self refresh was requested at the grant; otherwise RAS→PRE while catch-up rows remain, or RAS→IDLE.
- SELF→RPS when the minimum hold has elapsed and the command is low.
- RPS→PRE instead of RPS→IDLE when burst style is selected.

Top module: `dram_rfsh_mgr`

## Requirements
- R1: With `ext_period`=0, one refresh is owed every T_INT_STD cycles. When grants are always given, successive falls of `ras_n` are exactly T_INT_STD cycles apart.
- R2: In IDLE, `rf_req` is high when any refresh is owed or `sr_cmd` is high. Outside IDLE, `rf_req` stays high and `acc_ok` is low. Without `rf_gnt` the strobes do not move.
- R3: After a grant, both strobes stay high for T_RP cycles, then `cas_n` is low with `ras_n` high for T_CSR cycles, then both are low for T_RAS cycles. `ras_n` is never low while `cas_n` is high.
- R4: A refresh cycle that is not entering self refresh or continuing a burst ends with `ras_n`=1 and `cas_n`=1.
- R5: The backlog counter is MISS_W bits wide and saturates at 2^MISS_W−1. After the grant returns, the owed cycles are issued back to back, with one IDLE cycle between them.
- R6: If `sr_cmd` is high at the grant, both strobes stay low after the CBR cycle and `in_sr`=1. The SELF state lasts at least T_RASS cycles, even if `sr_cmd` drops at once.
- R7: On exit from SELF, both strobes are high and `acc_ok`=0 for exactly T_RPS cycles before IDLE.
- R8: With `burst_style`=1 at the end of the exit guard, ROWS CBR cycles run before `acc_ok` returns.
- R9: During SELF the interval timer and the backlog are cleared. The next refresh is owed T_INT_STD cycles after SELF ends.
- R10: With `ext_period`=1, refreshes are spaced T_INT_EXT cycles apart.
- R11: During reset, `ras_n`=1, `cas_n`=1, `rf_req`=0, `acc_ok`=1 and `in_sr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_period | input | 1 | 1 selects the extended refresh interval |
| burst_style | input | 1 | 1 runs a full catch-up burst after self-refresh exit |
| sr_cmd | input | 1 | Level: 1 asks for self refresh, 0 asks to leave it |
| rf_gnt | input | 1 | Sequencer grants the strobes (sampled in IDLE) |
| rf_req | output | 1 | Request for, or ownership of, the strobes |
| acc_ok | output | 1 | Access cycles may be started (IDLE) |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| in_sr | output | 1 | DRAM is held in self refresh |

## Verification
All strobes and status outputs are registered. A grant seen at a clock edge therefore moves the strobes on the very next edge, and the two self-refresh edges show up on the first edge after the count ends. Only `rf_req` also follows `sr_cmd` at once. A behavioural model in the bench queues the expected strobe levels for each cycle, and the outputs are compared against it one time unit after every falling clock edge. By then the registered outputs have settled and the inputs driven at that edge are visible. Directed checks count falling-edge samples to measure the interval spacing, the minimum self-refresh hold, the exit guard and the number of catch-up rows.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_CAS,
        S_RAS,
        S_SELF,
        S_RPS
    } rfsh_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
    parameter int unsigned T_STD  = 780,
    parameter int unsigned T_EXT  = 6250,
    parameter int unsigned MISS_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_period,
    input  logic hold,
    input  logic take,
    output logic pend_nz
);
    localparam int unsigned TW = $clog2(rfsh_pkg::max2(T_STD, T_EXT) + 1);
    localparam logic [TW-1:0] LIM_STD = TW'(T_STD - 1);
    localparam logic [TW-1:0] LIM_EXT = TW'(T_EXT - 1);
    localparam logic [MISS_W-1:0] PEND_MAX = '1;

    logic [TW-1:0]     tmr;
    logic [TW-1:0]     lim;
    logic [MISS_W-1:0] pend;
    logic              tick;
    logic              take_ok;

    assign lim     = ext_period ? LIM_EXT : LIM_STD;
    assign tick    = !hold && (tmr >= lim);
    assign take_ok = take && (pend != '0);
    assign pend_nz = (pend != '0);

    // interval timer, frozen at zero while the DRAM refreshes itself
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if (hold || tick) begin
            tmr <= '0;
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

    // backlog of owed refresh cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (hold) begin
            pend <= '0;
        end else if (tick && !take_ok) begin
            if (pend != PEND_MAX) begin
                pend <= pend + 1'b1;
            end
        end else if (take_ok && !tick) begin
            pend <= pend - 1'b1;
        end
    end

    p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == PEND_MAX && tick && !take) |=> (pend == PEND_MAX));

    p_hold_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (pend == '0 && tmr == '0));

endmodule

// File: rtl/rfsh_fsm.sv
module rfsh_fsm
    import rfsh_pkg::*;
#(
    parameter int unsigned T_RP   = 3,
    parameter int unsigned T_CSR  = 1,
    parameter int unsigned T_RAS  = 3,
    parameter int unsigned T_RASS = 5000,
    parameter int unsigned T_RPS  = 6,
    parameter int unsigned ROWS   = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_ref,
    input  logic sr_cmd,
    input  logic burst_style,
    input  logic rf_gnt,
    output logic take,
    output logic rf_req,
    output logic acc_ok,
    output logic ras_n,
    output logic cas_n,
    output logic in_sr
);
    localparam int unsigned TMAX = max2(max2(max2(T_RP, T_CSR), max2(T_RAS, T_RPS)), T_RASS);
    localparam int unsigned CW   = $clog2(TMAX + 1);
    localparam int unsigned BW   = $clog2(ROWS + 1);
    localparam logic [CW-1:0] L_RP   = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_CSR  = CW'(T_CSR - 1);
    localparam logic [CW-1:0] L_RAS  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_RASS = CW'(T_RASS - 1);
    localparam logic [CW-1:0] L_RPS  = CW'(T_RPS - 1);

    rfsh_state_e   state;
    rfsh_state_e   state_nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic [BW-1:0] burst_left;
    logic          sr_go;
    logic          done;
    logic          want;
    logic          grant;

    assign want  = want_ref || sr_cmd;
    assign grant = (state == S_IDLE) && want && rf_gnt;
    assign take  = grant && want_ref;
    assign done  = (cnt == lim);

    always_comb begin
        unique case (state)
            S_PRE:   lim = L_RP;
            S_CAS:   lim = L_CSR;
            S_RAS:   lim = L_RAS;
            S_SELF:  lim = L_RASS;
            S_RPS:   lim = L_RPS;
            default: lim = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (grant) state_nxt = S_PRE;
            S_PRE:  if (done) state_nxt = S_CAS;
            S_CAS:  if (done) state_nxt = S_RAS;
            S_RAS: begin
                if (done) begin
                    if (sr_go) begin
                        state_nxt = S_SELF;
                    end else if (burst_left != '0) begin
                        state_nxt = S_PRE;
                    end else begin
                        state_nxt = S_IDLE;
                    end
                end
            end
            S_SELF: if (done && !sr_cmd) state_nxt = S_RPS;
            S_RPS: begin
                if (done) begin
                    state_nxt = burst_style ? S_PRE : S_IDLE;
                end
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    // phase counter, self-refresh flag and catch-up row count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            sr_go      <= 1'b0;
            burst_left <= '0;
        end else begin
            if (state_nxt != state) begin
                cnt <= '0;
            end else if (!done) begin
                cnt <= cnt + 1'b1;
            end
            if (grant) begin
                sr_go <= sr_cmd;
            end else if (state == S_RAS && done && sr_go) begin
                sr_go <= 1'b0;
            end
            if (state == S_RPS && done && burst_style) begin
                burst_left <= BW'(ROWS - 1);
            end else if (state == S_RAS && done && !sr_go && burst_left != '0) begin
                burst_left <= burst_left - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ras_n  = 1'b1;
        cas_n  = 1'b1;
        acc_ok = 1'b0;
        in_sr  = 1'b0;
        rf_req = 1'b1;
        unique case (state)
            S_IDLE: begin
                acc_ok = 1'b1;
                rf_req = want;
            end
            S_CAS: cas_n = 1'b0;
            S_RAS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            S_SELF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                in_sr = 1'b1;
            end
            default: begin
            end
        endcase
    end

    p_cbr_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    p_cas_leads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cas_n) == 1'b0));

    p_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> (rf_req && !acc_ok));

    p_standby_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RAS && done && !sr_go && burst_left == '0) |=> (ras_n && cas_n && acc_ok));

    p_sr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sr && !done) |=> in_sr);

    p_rps_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sr) |-> (ras_n && cas_n && !acc_ok));

endmodule

// File: rtl/dram_rfsh_mgr.sv
module dram_rfsh_mgr #(
    parameter int unsigned T_INT_STD = 780,
    parameter int unsigned T_INT_EXT = 6250,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_CSR     = 1,
    parameter int unsigned T_RAS     = 3,
    parameter int unsigned T_RASS    = 5000,
    parameter int unsigned T_RPS     = 6,
    parameter int unsigned ROWS      = 4096,
    parameter int unsigned MISS_W    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_period,
    input  logic burst_style,
    input  logic sr_cmd,
    input  logic rf_gnt,
    output logic rf_req,
    output logic acc_ok,
    output logic ras_n,
    output logic cas_n,
    output logic in_sr
);
    logic pend_nz;
    logic take;

    rfsh_interval #(
        .T_STD (T_INT_STD),
        .T_EXT (T_INT_EXT),
        .MISS_W(MISS_W)
    ) u_interval (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_period(ext_period),
        .hold      (in_sr),
        .take      (take),
        .pend_nz   (pend_nz)
    );

    rfsh_fsm #(
        .T_RP  (T_RP),
        .T_CSR (T_CSR),
        .T_RAS (T_RAS),
        .T_RASS(T_RASS),
        .T_RPS (T_RPS),
        .ROWS  (ROWS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .want_ref   (pend_nz),
        .sr_cmd     (sr_cmd),
        .burst_style(burst_style),
        .rf_gnt     (rf_gnt),
        .take       (take),
        .rf_req     (rf_req),
        .acc_ok     (acc_ok),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .in_sr      (in_sr)
    );

    p_req_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && pend_nz) |-> rf_req);

endmodule

// File: tb/tb_dram_rfsh_mgr.sv
module tb_dram_rfsh_mgr;
    localparam int P_STD = 40, P_EXT = 90, P_RP = 2, P_CSR = 2, P_RAS = 3;
    localparam int P_RASS = 10, P_RPS = 5, P_ROWS = 4, P_MW = 3;
    localparam int PEND_MAX = (1 << P_MW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ext_period = 1'b0, burst_style = 1'b0, sr_cmd = 1'b0, rf_gnt = 1'b0;
    logic rf_req, acc_ok, ras_n, cas_n, in_sr;

    always #10 clk = ~clk;

    dram_rfsh_mgr #(
        .T_INT_STD(P_STD), .T_INT_EXT(P_EXT), .T_RP(P_RP), .T_CSR(P_CSR),
        .T_RAS(P_RAS), .T_RASS(P_RASS), .T_RPS(P_RPS), .ROWS(P_ROWS), .MISS_W(P_MW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ext_period(ext_period), .burst_style(burst_style),
        .sr_cmd(sr_cmd), .rf_gnt(rf_gnt), .rf_req(rf_req), .acc_ok(acc_ok),
        .ras_n(ras_n), .cas_n(cas_n), .in_sr(in_sr)
    );

    int checks = 0, errors = 0, cyc = 0, n_fall = 0;
    string tag = "R11";

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    // behavioural reference: queue of expected strobe levels per cycle
    typedef struct { bit ras; bit cas; int mark; } step_t;
    step_t q[$];
    int m_tmr = 0, m_pend = 0, m_scnt = 0, m_burst = 0;
    bit m_self = 0, m_srgo = 0;

    function automatic void push_seg(input bit r, input bit c, input int n, input int mk);
        for (int i = 0; i < n; i++) begin
            step_t s;
            s.ras = r; s.cas = c; s.mark = (i == n - 1) ? mk : 0;
            q.push_back(s);
        end
    endfunction

    function automatic void push_cbr();
        push_seg(1, 1, P_RP, 0);
        push_seg(1, 0, P_CSR, 0);
        push_seg(0, 0, P_RAS, 1);
    endfunction

    function automatic bit m_idle();
        return (q.size() == 0) && !m_self;
    endfunction

    always @(posedge clk) begin
        int lim;
        bit tick, take, was_self;
        step_t s;
        cyc++;
        if (!rst_n) begin
            q.delete();
            m_tmr = 0; m_pend = 0; m_scnt = 0; m_burst = 0; m_self = 0; m_srgo = 0;
        end else begin
            lim = ext_period ? P_EXT : P_STD;
            was_self = m_self;
            tick = !was_self && (m_tmr >= lim - 1);
            take = 0;
            if (m_self) begin
                if (m_scnt >= P_RASS - 1 && !sr_cmd) begin
                    m_self = 0;
                    push_seg(1, 1, P_RPS, 2);
                end else if (m_scnt < P_RASS - 1) begin
                    m_scnt++;
                end
            end else if (q.size() > 0) begin
                s = q.pop_front();
                if (s.mark == 1) begin
                    if (m_srgo) begin
                        m_srgo = 0; m_self = 1; m_scnt = 0;
                    end else if (m_burst > 0) begin
                        m_burst--; push_cbr();
                    end
                end else if (s.mark == 2 && burst_style) begin
                    m_burst = P_ROWS - 1; push_cbr();
                end
            end else if ((m_pend > 0 || sr_cmd) && rf_gnt) begin
                take = (m_pend > 0);
                m_srgo = sr_cmd;
                push_cbr();
            end
            if (was_self) begin
                m_tmr = 0; m_pend = 0;
            end else begin
                m_tmr = tick ? 0 : m_tmr + 1;
                if (tick && !take) m_pend = (m_pend < PEND_MAX) ? m_pend + 1 : PEND_MAX;
                else if (take && !tick) m_pend = m_pend - 1;
            end
        end
    end

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk({tag, " ras_n"}, int'(ras_n), m_self ? 0 : (q.size() > 0 ? int'(q[0].ras) : 1));
            chk({tag, " cas_n"}, int'(cas_n), m_self ? 0 : (q.size() > 0 ? int'(q[0].cas) : 1));
            chk({tag, " acc_ok"}, int'(acc_ok), int'(m_idle()));
            chk({tag, " in_sr"}, int'(in_sr), int'(m_self));
            chk({tag, " rf_req"}, int'(rf_req), int'(!m_idle() || m_pend > 0 || sr_cmd));
        end
    end

    always @(negedge ras_n) if (rst_n) n_fall++;

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t1, t2, n, n0, early;
        repeat (3) @(negedge clk);
        // R11 reset values
        chk("R11 ras_n", int'(ras_n), 1);
        chk("R11 cas_n", int'(cas_n), 1);
        chk("R11 rf_req", int'(rf_req), 0);
        chk("R11 acc_ok", int'(acc_ok), 1);
        chk("R11 in_sr", int'(in_sr), 0);
        rst_n = 1'b1;

        // R1 / R3: standard spacing and strobe order
        tag = "R3";
        rf_gnt = 1'b1;
        @(negedge ras_n); t1 = cyc;
        @(negedge clk); chk("R3 cas low at ras fall", int'(cas_n), 0);
        @(negedge ras_n); t2 = cyc;
        chk("R1 spacing", t2 - t1, P_STD);

        // R2: no grant, no strobe activity, request held
        tag = "R2";
        @(negedge clk); rf_gnt = 1'b0;
        n0 = n_fall;
        repeat (8 * P_STD + 10) @(negedge clk);
        chk("R2 no strobes without grant", n_fall - n0, 0);
        chk("R2 request held", int'(rf_req), 1);

        // R5: saturated backlog drained back to back
        tag = "R5";
        n0 = n_fall;
        rf_gnt = 1'b1;
        repeat (58) @(negedge clk);
        chk("R5 back-to-back count", n_fall - n0, PEND_MAX);

        // R10: extended interval
        tag = "R10";
        ext_period = 1'b1;
        repeat (2 * P_EXT) @(negedge clk);
        @(negedge ras_n); t1 = cyc;
        @(negedge ras_n); t2 = cyc;
        chk("R10 ext spacing", t2 - t1, P_EXT);
        @(negedge clk); ext_period = 1'b0;
        repeat (10) @(negedge clk);

        // R6 / R7: minimum hold and exit guard
        tag = "R6";
        sr_cmd = 1'b1;
        while (!in_sr) @(negedge clk);
        sr_cmd = 1'b0;
        n = 0;
        while (in_sr) begin n++; @(negedge clk); end
        chk("R6 self hold cycles", n, P_RASS);
        tag = "R7";
        n = 0;
        while (!acc_ok) begin
            chk("R7 strobes high in guard", int'(ras_n & cas_n), 1);
            n++; @(negedge clk);
        end
        chk("R7 guard cycles", n, P_RPS);

        // R9: timer cleared by self refresh
        tag = "R9";
        @(negedge clk); sr_cmd = 1'b1;
        while (!in_sr) @(negedge clk);
        repeat (3 * P_STD) @(negedge clk);
        sr_cmd = 1'b0;
        while (!acc_ok) @(negedge clk);
        early = 0;
        repeat (P_STD - P_RPS - 3) begin
            if (rf_req) early++;
            @(negedge clk);
        end
        chk("R9 no request right after exit", early, 0);
        repeat (6) @(negedge clk);
        chk("R9 request after one interval", int'(rf_req || !acc_ok), 1);

        // R8: catch-up burst after exit
        tag = "R8";
        repeat (20) @(negedge clk);
        burst_style = 1'b1;
        sr_cmd = 1'b1;
        while (!in_sr) @(negedge clk);
        sr_cmd = 1'b0;
        while (in_sr) @(negedge clk);
        n0 = n_fall;
        while (!acc_ok) @(negedge clk);
        chk("R8 burst rows", n_fall - n0, P_ROWS);
        burst_style = 1'b0;

        // R4: standby after a cycle, then random grants
        tag = "R4";
        @(negedge ras_n);
        @(posedge ras_n);
        @(negedge clk);
        chk("R4 both high after cycle", int'(ras_n & cas_n), 1);
        repeat (2000) begin
            @(negedge clk);
            rf_gnt = 1'($urandom_range(0, 1));
        end
        repeat (5) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule